// File: doc/BRIEF.md
# Host Port Slave Interface

This block lets an external host reach a processor's internal memory through a 16-bit halfword bus. The host selects one of three registers with a two-bit select field: a control register, the address register(s) and a data register. Address and data values are 32 bits wide, so the host moves them as two halfword accesses. Data accesses turn into single-word requests on a 32-bit request/acknowledge memory port, and that port may take any number of cycles to acknowledge.

A host access starts on the first clock edge at which chip select is sampled high. The host keeps chip select high until it samples the active-low ready output low, then releases it. The processor side can write a few control bits and can read back the whole control word. Interrupts run in both directions: a one-cycle pulse toward the processor, and an active-low level toward the host.

A port-reset bit in the control register takes its reset value from a boot-mode strap. While that bit is set, control and address accesses still work, but data accesses never report ready and read as zero. A configuration input chooses whether address register contents are byte addresses or 32-bit word addresses.

Top module: `host_port_slave`

## Requirements
- R1: After reset the control word reads 0x00000088 when `boot_host_i` is 0, and 0x00000008 when it is 1. `hint_no` is 1, `hrdy_no` is 0 and `mem_req_o` is 0.
- R2: Control bit 0 sets the halfword order. With bit 0 = 0 the first halfword (`hsecond_i`=0) carries bits 31:16; with bit 0 = 1 it carries bits 15:0. The order applies to address and data accesses in both directions. Bit 8 always reads the same value as bit 0.
- R3: A host control write with data bit 1 = 1 drives `cpu_irq_o` high for exactly one cycle. A write with bit 1 = 0 produces no pulse. Bit 1 always reads 0.
- R4: A processor write with bit 2 = 1 sets control bit 2 and drives `hint_no` low. A host control write with bit 2 = 1 clears the bit and drives `hint_no` high. A write with bit 2 = 0 from either side leaves it unchanged. If both sides set and clear in the same cycle, the processor's set wins.
- R5: When bit 9 = 0, a host address write updates both the read and write address registers, and an address read returns the read register. When bit 9 = 1, bit 11 selects the register: 0 selects the write register, 1 selects the read register.
- R6: The processor can change only bits 7 and 2; its other written bits have no effect. The host can change bits 0, 9 and 11, and can clear bit 2. Bit 4 (the host fetch request) and all reserved bits read 0, except bit 3, which reads 1.
- R7: While bit 7 = 1, a data access keeps `hrdy_no` high for as long as chip select stays high. It returns 0 on `hdata_o`, issues no memory request, and stores no write data. Control and address accesses complete with no wait.
- R8: The first halfword of a data read issues a memory read of the read address and holds `hrdy_no` high until the acknowledge. The second halfword is returned with no wait and no new request. An idle port shows `hrdy_no` = 0.
- R9: The first halfword of a data write is stored with no wait. The second halfword posts one memory write of the merged word to the write address, and `hrdy_no` stays high until the acknowledge. The request, address and write flag hold steady while they wait.
- R10: With `byte_mode_i` = 1 the memory address equals the address register. With `byte_mode_i` = 0 it is the address register shifted left by two.
- R11: Select code 00 addresses the control register, 01 the address register(s), 10 the data register; code 11 reads 0 and ignores writes. Control accesses carry bits 15:0 of the control word whichever halfword is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_host_i | input | 1 | Boot strap: 1 = host-port boot, port-reset bit resets to 0 |
| byte_mode_i | input | 1 | 1 = byte addressing, 0 = word addressing |
| cpu_wr_i | input | 1 | Processor control write strobe |
| cpu_wdata_i | input | 32 | Processor control write data |
| cpu_ctl_o | output | 32 | Control word as seen by the processor |
| cpu_irq_o | output | 1 | One-cycle interrupt pulse to the processor |
| hcs_i | input | 1 | Host chip select, active high |
| hread_i | input | 1 | 1 = read, 0 = write |
| hsel_i | input | 2 | Register select |
| hsecond_i | input | 1 | 0 = first halfword, 1 = second halfword |
| hdata_i | input | 16 | Host write data |
| hdata_o | output | 16 | Host read data |
| hrdy_no | output | 1 | Ready, active low |
| hint_no | output | 1 | Host interrupt, active low |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
Control and address writes take effect at the first edge of the access, so the bench reads their results at the falling edge that follows. The processor interrupt pulse comes one cycle after that edge, and a falling-edge monitor counts it so that its width is checked regardless of when the access task returns. Data results arrive after a memory latency that the bench sets, so the access task polls `hrdy_no` at falling edges, counts wait cycles, and captures `hdata_o` only once ready is seen low. A port-reset hold is detected by a bounded wait that expires while chip select is still high.

// File: rtl/hps_pkg.sv
package hps_pkg;
  typedef enum logic [1:0] {
    SEL_CTL = 2'b00,
    SEL_ADR = 2'b01,
    SEL_DAT = 2'b10,
    SEL_NONE = 2'b11
  } hsel_e;

  typedef enum logic [1:0] {
    XF_IDLE,
    XF_RD,
    XF_WR,
    XF_HOLD
  } xfer_st_e;

  localparam int unsigned CB_HWOB   = 0;
  localparam int unsigned CB_DSPIRQ = 1;
  localparam int unsigned CB_HINT   = 2;
  localparam int unsigned CB_ONE    = 3;
  localparam int unsigned CB_PRST   = 7;
  localparam int unsigned CB_HWOBST = 8;
  localparam int unsigned CB_DUAL   = 9;
  localparam int unsigned CB_ASEL   = 11;

  typedef struct packed {
    logic asel;
    logic dual;
    logic prst;
    logic hint;
    logic hwob;
  } ctl_t;

  // upper half addressed when first-halfword xor low-first order
  function automatic logic upper_half(input logic second, input logic hwob);
    return (~second) ^ hwob;
  endfunction
endpackage

// File: rtl/hps_ctrl.sv
module hps_ctrl
  import hps_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_host_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          host_wr_i,
  input  logic [HW-1:0] host_wdata_i,
  output ctl_t          ctl_o,
  output logic [DW-1:0] ctl_word_o,
  output logic          irq_o
);
  ctl_t ctl_q;
  logic irq_q;
  logic unused_wbits;

  assign unused_wbits = ^{cpu_wdata_i[DW-1:CB_PRST+1], cpu_wdata_i[CB_PRST-1:CB_HINT+1],
                          cpu_wdata_i[CB_HINT-1:0], host_wdata_i[HW-1:CB_ASEL+1],
                          host_wdata_i[CB_ASEL-1:CB_DUAL+1], host_wdata_i[CB_DUAL-1:CB_HINT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q.hwob <= 1'b0;
      ctl_q.dual <= 1'b0;
      ctl_q.asel <= 1'b0;
      ctl_q.hint <= 1'b0;
      ctl_q.prst <= ~boot_host_i;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= host_wr_i & host_wdata_i[CB_DSPIRQ];
      if (host_wr_i) begin
        ctl_q.hwob <= host_wdata_i[CB_HWOB];
        ctl_q.dual <= host_wdata_i[CB_DUAL];
        ctl_q.asel <= host_wdata_i[CB_ASEL];
      end
      if (cpu_wr_i) ctl_q.prst <= cpu_wdata_i[CB_PRST];
      // processor set takes priority over host clear
      if (cpu_wr_i && cpu_wdata_i[CB_HINT]) ctl_q.hint <= 1'b1;
      else if (host_wr_i && host_wdata_i[CB_HINT]) ctl_q.hint <= 1'b0;
    end
  end

  always_comb begin
    ctl_word_o             = '0;
    ctl_word_o[CB_HWOB]    = ctl_q.hwob;
    ctl_word_o[CB_HINT]    = ctl_q.hint;
    ctl_word_o[CB_ONE]     = 1'b1;
    ctl_word_o[CB_PRST]    = ctl_q.prst;
    ctl_word_o[CB_HWOBST]  = ctl_q.hwob;
    ctl_word_o[CB_DUAL]    = ctl_q.dual;
    ctl_word_o[CB_ASEL]    = ctl_q.asel;
  end

  assign ctl_o = ctl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/hps_addr.sv
module hps_addr #(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          upper_i,
  input  logic [HW-1:0] wdata_i,
  input  logic          dual_i,
  input  logic          asel_i,
  output logic [DW-1:0] rd_addr_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [HW-1:0] rdbk_o
);
  logic [DW-1:0] rd_q, wr_q, view;
  logic          hit_rd, hit_wr;

  assign hit_rd = ~dual_i | asel_i;
  assign hit_wr = ~dual_i | ~asel_i;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[h*HW +: HW] <= '0;
        wr_q[h*HW +: HW] <= '0;
      end else if (wr_i && (upper_i == logic'(h))) begin
        if (hit_rd) rd_q[h*HW +: HW] <= wdata_i;
        if (hit_wr) wr_q[h*HW +: HW] <= wdata_i;
      end
    end
  end

  assign view      = (dual_i && !asel_i) ? wr_q : rd_q;
  assign rdbk_o    = upper_i ? view[DW-1:HW] : view[HW-1:0];
  assign rd_addr_o = rd_q;
  assign wr_addr_o = wr_q;
endmodule

// File: rtl/hps_xfer.sv
module hps_xfer
  import hps_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW,
  localparam int unsigned SHIFT = $clog2(DW / 8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          read_i,
  input  logic          second_i,
  input  logic          upper_i,
  input  logic          hcs_i,
  input  logic [HW-1:0] hdata_i,
  input  logic          prst_i,
  input  logic          byte_mode_i,
  input  logic [DW-1:0] rd_addr_i,
  input  logic [DW-1:0] wr_addr_i,
  output logic [HW-1:0] rdata_o,
  output logic          rdy_no,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  xfer_st_e      st_q;
  logic [DW-1:0] rbuf_q, wbuf_q, addr_q, wdat_q, merged;
  logic          we_q, need_wait;

  function automatic logic [DW-1:0] xlate(input logic [DW-1:0] a, input logic bm);
    return bm ? a : (a << SHIFT);
  endfunction

  assign merged = upper_i ? {hdata_i, wbuf_q[HW-1:0]} : {wbuf_q[DW-1:HW], hdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= XF_IDLE;
      rbuf_q <= '0;
      wbuf_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      we_q   <= 1'b0;
    end else begin
      unique case (st_q)
        XF_IDLE: if (start_i) begin
          if (prst_i) begin
            st_q <= XF_HOLD;
          end else if (read_i) begin
            if (!second_i) begin
              addr_q <= xlate(rd_addr_i, byte_mode_i);
              we_q   <= 1'b0;
              st_q   <= XF_RD;
            end
          end else begin
            wbuf_q <= merged;
            if (second_i) begin
              addr_q <= xlate(wr_addr_i, byte_mode_i);
              wdat_q <= merged;
              we_q   <= 1'b1;
              st_q   <= XF_WR;
            end
          end
        end
        XF_RD: if (mem_ack_i) begin
          rbuf_q <= mem_rdata_i;
          st_q   <= XF_IDLE;
        end
        XF_WR: if (mem_ack_i) st_q <= XF_IDLE;
        XF_HOLD: if (!hcs_i) st_q <= XF_IDLE;
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  assign need_wait   = start_i & (prst_i | (read_i ^ second_i));
  assign rdy_no      = (st_q != XF_IDLE) | need_wait;
  assign rdata_o     = prst_i ? '0 : (upper_i ? rbuf_q[DW-1:HW] : rbuf_q[HW-1:0]);
  assign mem_req_o   = (st_q == XF_RD) || (st_q == XF_WR);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdat_q;
endmodule

// File: rtl/host_port_slave.sv
module host_port_slave
  import hps_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_host_i,
  input  logic          byte_mode_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_ctl_o,
  output logic          cpu_irq_o,
  input  logic          hcs_i,
  input  logic          hread_i,
  input  logic [1:0]    hsel_i,
  input  logic          hsecond_i,
  input  logic [HW-1:0] hdata_i,
  output logic [HW-1:0] hdata_o,
  output logic          hrdy_no,
  output logic          hint_no,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  ctl_t          ctl;
  logic          cs_q, start, upper;
  logic          ctl_wr, adr_wr, dat_start;
  logic [DW-1:0] ctl_word, rd_addr, wr_addr;
  logic [HW-1:0] adr_rdbk, dat_rdata;
  hsel_e         sel;

  assign sel = hsel_e'(hsel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= hcs_i;
  end

  assign start     = hcs_i & ~cs_q;
  assign upper     = upper_half(hsecond_i, ctl.hwob);
  assign ctl_wr    = start & ~hread_i & (sel == SEL_CTL);
  assign adr_wr    = start & ~hread_i & (sel == SEL_ADR);
  assign dat_start = start & (sel == SEL_DAT);

  hps_ctrl #(.HW(HW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_host_i (boot_host_i),
    .cpu_wr_i    (cpu_wr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .host_wr_i   (ctl_wr),
    .host_wdata_i(hdata_i),
    .ctl_o       (ctl),
    .ctl_word_o  (ctl_word),
    .irq_o       (cpu_irq_o)
  );

  hps_addr #(.HW(HW)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (adr_wr),
    .upper_i  (upper),
    .wdata_i  (hdata_i),
    .dual_i   (ctl.dual),
    .asel_i   (ctl.asel),
    .rd_addr_o(rd_addr),
    .wr_addr_o(wr_addr),
    .rdbk_o   (adr_rdbk)
  );

  hps_xfer #(.HW(HW)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (dat_start),
    .read_i      (hread_i),
    .second_i    (hsecond_i),
    .upper_i     (upper),
    .hcs_i       (hcs_i),
    .hdata_i     (hdata_i),
    .prst_i      (ctl.prst),
    .byte_mode_i (byte_mode_i),
    .rd_addr_i   (rd_addr),
    .wr_addr_i   (wr_addr),
    .rdata_o     (dat_rdata),
    .rdy_no      (hrdy_no),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i)
  );

  always_comb begin
    unique case (sel)
      SEL_CTL: hdata_o = ctl_word[HW-1:0];
      SEL_ADR: hdata_o = adr_rdbk;
      SEL_DAT: hdata_o = dat_rdata;
      default: hdata_o = '0;
    endcase
  end

  assign cpu_ctl_o = ctl_word;
  assign hint_no   = ~ctl.hint;
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_wr_i,
  input logic [DW-1:0] cpu_wdata_i,
  input logic [DW-1:0] cpu_ctl_o,
  input logic          cpu_irq_o,
  input logic          hcs_i,
  input logic          hrdy_no,
  input logic          hint_no,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_ack_i
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |=> !cpu_irq_o); // R3

  AST_HINT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_wdata_i[2]) |=> !hint_no); // R4

  AST_HOLD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ctl_o[7] && !mem_req_o) |=> !mem_req_o); // R7

  AST_WAIT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> hrdy_no); // R8

  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!hcs_i) && !hcs_i && !mem_req_o) |-> !hrdy_no); // R8

  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R9
endmodule

bind host_port_slave hps_checker #(.DW(DW)) u_hps_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_wr_i   (cpu_wr_i),
  .cpu_wdata_i(cpu_wdata_i),
  .cpu_ctl_o  (cpu_ctl_o),
  .cpu_irq_o  (cpu_irq_o),
  .hcs_i      (hcs_i),
  .hrdy_no    (hrdy_no),
  .hint_no    (hint_no),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/host_port_slave_bench.sv
module host_port_slave_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boot_host = 1'b0;
  logic        byte_mode = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_ctl;
  logic        cpu_irq;
  logic        hcs = 1'b0;
  logic        hread = 1'b0;
  logic [1:0]  hsel = 2'b00;
  logic        hsecond = 1'b0;
  logic [15:0] hdin = '0;
  logic [15:0] hdout;
  logic        hrdy_n, hint_n;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int vectors = 0, errors = 0, irq_cnt = 0, req_cycles = 0;
  int lat = 2, cnt = 0;
  logic [31:0] mem [16];
  logic [31:0] last_wa = '0;
  logic        pre_we = 1'b0;
  logic [3:0]  pre_idx = '0;
  logic [31:0] pre_val = '0;
  bit          done = 0;

  always #4 clk = ~clk;

  host_port_slave u_host_port_slave (
    .clk_i(clk), .rst_ni(rst_ni), .boot_host_i(boot_host), .byte_mode_i(byte_mode),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_ctl_o(cpu_ctl), .cpu_irq_o(cpu_irq),
    .hcs_i(hcs), .hread_i(hread), .hsel_i(hsel), .hsecond_i(hsecond), .hdata_i(hdin),
    .hdata_o(hdout), .hrdy_no(hrdy_n), .hint_no(hint_n),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // memory model with programmable latency
  always @(posedge clk) begin
    if (pre_we) mem[pre_idx] <= pre_val;
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        cnt <= 0;
        if (mem_we) begin
          mem[mem_addr[5:2]] <= mem_wdata;
          last_wa <= mem_addr;
        end else mem_rdata <= mem[mem_addr[5:2]];
      end else cnt <= cnt + 1;
    end else mem_ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (cpu_irq) irq_cnt++;
    if (mem_req) req_cycles++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk); pre_we = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic host_acc(input logic rd, input logic [1:0] sel, input logic second,
                          input logic [15:0] wd, input int max_wait,
                          output logic [15:0] rdv, output int waits, output bit tmo);
    @(negedge clk);
    hcs = 1'b1; hread = rd; hsel = sel; hsecond = second; hdin = wd;
    waits = 0; tmo = 0;
    @(negedge clk);
    while (hrdy_n && !tmo) begin
      waits++;
      if (waits >= max_wait) tmo = 1;
      else @(negedge clk);
    end
    rdv = hdout;
    hcs = 1'b0;
    @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] sel, input logic second, input logic [15:0] wd);
    logic [15:0] r; int w; bit t;
    host_acc(1'b0, sel, second, wd, 50, r, w, t);
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk); rst_ni = 1'b0; boot_host = boot;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 ctl after reset strap0", cpu_ctl, 32'h0000_0088);
    chk("R1 hint_no", {31'b0, hint_n}, 32'd1);
    chk("R1 hrdy_no", {31'b0, hrdy_n}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_hold;
    logic [15:0] r; int w; bit t; int rc;
    rc = req_cycles;
    host_acc(1'b1, 2'b10, 1'b0, 16'h0, 12, r, w, t);
    chk("R7 data read never ready", {31'b0, t}, 32'd1);
    chk("R7 data reads zero", {16'b0, r}, 32'd0);
    host_acc(1'b0, 2'b10, 1'b1, 16'hAAAA, 12, r, w, t);
    chk("R7 data write never ready", {31'b0, t}, 32'd1);
    chk("R7 no memory request", rc, req_cycles);
    chk("R7 ready after cs released", {31'b0, hrdy_n}, 32'd0);
    host_acc(1'b1, 2'b00, 1'b0, 16'h0, 12, r, w, t);
    chk("R7 control read completes", {w, 15'b0, t}, 32'd0);
    chk("R7 control read value", {16'b0, r}, 32'h0000_0088);
    hwr(2'b01, 1'b0, 16'h0004);
    host_acc(1'b1, 2'b01, 1'b1, 16'h0, 12, r, w, t);
    chk("R7 address access completes", {w, 15'b0, t}, 32'd0);
  endtask

  task automatic t_ctl_bits;
    logic [15:0] r; int w; bit t; int ic;
    cpu_write(32'h0000_0000);
    chk("R6 port reset released", cpu_ctl, 32'h0000_0008);
    hwr(2'b00, 1'b0, 16'h0001);
    chk("R2 hwob and mirror", cpu_ctl, 32'h0000_0109);
    host_acc(1'b1, 2'b00, 1'b1, 16'h0, 50, r, w, t);
    chk("R11 control on second halfword", {16'b0, r}, 32'h0000_0109);
    ic = irq_cnt;
    hwr(2'b00, 1'b0, 16'h0013); // bits 4 and 1 set, hwob kept
    repeat (2) @(negedge clk);
    chk("R3 one pulse of one cycle", irq_cnt - ic, 32'd1);
    chk("R6 fetch and irq bits read 0", cpu_ctl, 32'h0000_0109);
    hwr(2'b00, 1'b0, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R3 write of 0 gives no pulse", irq_cnt - ic, 32'd1);
    cpu_write(32'hFFFF_FF7B); // all but bit 7 and bit 2
    chk("R6 cpu writes ignored bits", cpu_ctl, 32'h0000_0109);
    hwr(2'b11, 1'b0, 16'hFFFF);
    chk("R11 select 11 write ignored", cpu_ctl, 32'h0000_0109);
    host_acc(1'b1, 2'b11, 1'b0, 16'h0, 50, r, w, t);
    chk("R11 select 11 reads 0", {16'b0, r}, 32'd0);
  endtask

  task automatic t_hint;
    cpu_write(32'h0000_0004);
    chk("R4 cpu set drives pin low", {31'b0, hint_n}, 32'd0);
    chk("R4 bit reads 1", cpu_ctl, 32'h0000_010D);
    cpu_write(32'h0000_0000);
    hwr(2'b00, 1'b0, 16'h0001);
    chk("R4 zero writes no effect", {31'b0, hint_n}, 32'd0);
    hwr(2'b00, 1'b0, 16'h0005);
    chk("R4 host clears pin", {31'b0, hint_n}, 32'd1);
    chk("R4 bit cleared", cpu_ctl, 32'h0000_0109);
  endtask

  task automatic t_read_word;
    logic [15:0] r; int w; bit t; int rc;
    byte_mode = 1'b0;
    preload(4'd4, 32'h1234_0FED);
    hwr(2'b01, 1'b0, 16'h0004); // low half first (hwob=1)
    hwr(2'b01, 1'b1, 16'h0000);
    lat = 3;
    host_acc(1'b1, 2'b10, 1'b0, 16'h0, 50, r, w, t);
    chk("R10 R2 first half low", {16'b0, r}, 32'h0000_0FED);
    chk("R8 first half waited", {31'b0, (w > 0)}, 32'd1);
    chk("R10 word address shifted", mem_addr, 32'h0000_0010);
    rc = req_cycles;
    host_acc(1'b1, 2'b10, 1'b1, 16'h0, 50, r, w, t);
    chk("R8 second half high", {16'b0, r}, 32'h0000_1234);
    chk("R8 second half no wait", w, 0);
    chk("R8 no new request", req_cycles, rc);
    hwr(2'b00, 1'b0, 16'h0000); // hwob=0
    chk("R2 mirror cleared", cpu_ctl, 32'h0000_0008);
    host_acc(1'b1, 2'b10, 1'b0, 16'h0, 50, r, w, t);
    chk("R2 first half high when hwob=0", {16'b0, r}, 32'h0000_1234);
    host_acc(1'b1, 2'b01, 1'b1, 16'h0, 50, r, w, t);
    chk("R2 address second half low", {16'b0, r}, 32'h0000_0004);
  endtask

  task automatic t_write_word;
    logic [15:0] r; int w; bit t;
    hwr(2'b00, 1'b0, 16'h0001);
    hwr(2'b01, 1'b0, 16'h0008);
    hwr(2'b01, 1'b1, 16'h0000);
    lat = 4;
    host_acc(1'b0, 2'b10, 1'b0, 16'hBEEF, 50, r, w, t);
    chk("R9 first half no wait", w, 0);
    host_acc(1'b0, 2'b10, 1'b1, 16'hCAFE, 50, r, w, t);
    chk("R9 second half waited", {31'b0, (w > 0)}, 32'd1);
    chk("R9 merged word", mem[8], 32'hCAFE_BEEF);
    chk("R10 write address word mode", last_wa, 32'h0000_0020);
  endtask

  task automatic t_dual;
    logic [15:0] r; int w; bit t;
    byte_mode = 1'b1;
    preload(4'd6, 32'h5566_7788);
    hwr(2'b00, 1'b0, 16'h0201);
    chk("R5 dual set", cpu_ctl, 32'h0000_0309);
    hwr(2'b01, 1'b0, 16'h0024);
    hwr(2'b01, 1'b1, 16'h0000);
    hwr(2'b00, 1'b0, 16'h0A01);
    hwr(2'b01, 1'b0, 16'h0018);
    hwr(2'b01, 1'b1, 16'h0000);
    host_acc(1'b1, 2'b01, 1'b0, 16'h0, 50, r, w, t);
    chk("R5 read register selected", {16'b0, r}, 32'h0000_0018);
    host_acc(1'b1, 2'b10, 1'b0, 16'h0, 50, r, w, t);
    chk("R10 byte mode read", mem_addr, 32'h0000_0018);
    chk("R5 read via read register", {16'b0, r}, 32'h0000_7788);
    hwr(2'b00, 1'b0, 16'h0201);
    host_acc(1'b1, 2'b01, 1'b0, 16'h0, 50, r, w, t);
    chk("R5 write register kept", {16'b0, r}, 32'h0000_0024);
    hwr(2'b10, 1'b0, 16'h3333);
    hwr(2'b10, 1'b1, 16'h4444);
    chk("R5 R10 write via write register", last_wa, 32'h0000_0024);
    chk("R9 data in dual mode", mem[9], 32'h4444_3333);
  endtask

  task automatic t_boot_strap;
    do_reset(1'b1);
    chk("R1 ctl after reset strap1", cpu_ctl, 32'h0000_0008);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_ctl_bits();
    t_hint();
    t_read_word();
    t_write_word();
    t_dual();
    t_boot_strap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule